// File: doc/BRIEF.md
# Halt and Idle Power Mode Controller

This block sequences the power modes of a small microcontroller. Software reaches it through a byte-wide register bus. A write to the mode control register puts the device into one of two low-power states. In the deep halt state the oscillator, the analog comparator and the brown-out detector are all switched off. The lighter idle state only stops the CPU and leaves those circuits running.

The two states end on different events. Halt ends only on the wakeup input. Idle ends on either the wakeup input or a timer overflow. When halt ends, the block holds the CPU in a counted recovery phase while the oscillator settles, and only then raises the CPU run enable. Idle returns straight to normal running with no recovery phase.

Each exit from a low-power state sets a resume flag. The flag stays set until software acknowledges it by writing zero to a separate acknowledge register. The recovery length is a parameter. It is counted on the block's clock, which is assumed to keep running during halt.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the block in normal mode: mode code 00, cpu_run, osc_en, comp_en and bor_en all 1, and resume_flag 0.
- R2: In normal mode, writing a value with bit 0 set to the mode control register (byte address 0xB7) enters halt on the next clock edge. Halt shows mode code 01, with cpu_run, osc_en, comp_en and bor_en all 0.
- R3: In normal mode, writing 0x02 to address 0xB7 enters idle on the next clock edge. Idle shows mode code 10, with cpu_run 0 and osc_en, comp_en and bor_en all 1.
- R4: A write to 0xB7 that sets both bit 0 and bit 1 (0x03) enters halt, not idle.
- R5: While in halt, the timer overflow input has no effect, and the block stays in halt until wake_i is sampled high.
- R6: When wake_i is sampled high in halt, the block enters recovery (mode code 11) for exactly REC_CYC cycles. During recovery cpu_run is 0 and osc_en, comp_en and bor_en are 1. After that it returns to normal mode.
- R7: In idle, wake_i or tmr_ovf_i sampled high returns the block to normal mode on the next edge, with no recovery phase.
- R8: A read of address 0xB7 returns 0x00 in every state, because the request bits are write-only and bits 7 to 2 are reserved.
- R9: Leaving halt or idle sets resume_flag. Only a write of 0x00 to the acknowledge register (byte address 0xB8) clears it; a nonzero write there leaves it set. A read of 0xB8 returns the flag in bit 0 and zeros above.
- R10: A write to 0xB7 with neither bit 0 nor bit 1 set, or a write to any other address, leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, running in all modes |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| wake_i | input | 1 | Wakeup event from the external wakeup logic |
| tmr_ovf_i | input | 1 | Timer overflow event |
| cpu_run | output | 1 | CPU run enable |
| osc_en | output | 1 | Oscillator enable |
| comp_en | output | 1 | Analog comparator enable |
| bor_en | output | 1 | Brown-out detector enable |
| mode_code | output | 2 | 00 normal, 01 halt, 10 idle, 11 recovery |
| resume_flag | output | 1 | Set on leaving a low-power mode, cleared by acknowledge |

## Verification
The bench drives timer overflows into halt to show that a design treating halt like idle would leave halt early. It checks that recovery lasts exactly REC_CYC cycles, so an off-by-one counter or an idle exit that wrongly passes through recovery shows up as a mode-code mismatch. A simultaneous 0x03 write catches reversed priority. Nonzero acknowledge writes, reserved-bit writes and reads of the write-only bits expose a flag cleared too easily, a spurious mode entry, or request bits leaking onto the read bus.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_NORM  = 2'b00,
    PM_HALT  = 2'b01,
    PM_IDLE  = 2'b10,
    PM_RECOV = 2'b11
  } pm_mode_e;

  // {cpu_run, osc_en, comp_en, bor_en} for each mode
  function automatic logic [3:0] enables_for(pm_mode_e m);
    case (m)
      PM_NORM:  return 4'b1111;
      PM_HALT:  return 4'b0000;
      PM_IDLE:  return 4'b0111;
      default:  return 4'b0111;
    endcase
  endfunction

  // recovery is complete on the last of lim counted cycles
  function automatic logic rec_last(input int unsigned cnt, input int unsigned lim);
    return cnt == lim - 1;
  endfunction

endpackage

// File: rtl/pmc_regif.sv
module pmc_regif #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'hB7,
  parameter logic [AW-1:0] ACK_ADDR  = 8'hB8,
  parameter int HALT_BIT = 0,
  parameter int IDLE_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          flag_i,
  output logic [DW-1:0] bus_rdata,
  output logic          halt_req,
  output logic          idle_req,
  output logic          ack_req
);

  logic ctrl_hit, ack_hit;

  assign ctrl_hit = bus_wr && (bus_addr == CTRL_ADDR);
  assign ack_hit  = bus_wr && (bus_addr == ACK_ADDR);

  // halt wins when both request bits are written together
  assign halt_req = ctrl_hit && bus_wdata[HALT_BIT];
  assign idle_req = ctrl_hit && bus_wdata[IDLE_BIT] && !bus_wdata[HALT_BIT];
  assign ack_req  = ack_hit && (bus_wdata == '0);

  // request bits are write-only: the control address always reads zero
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ACK_ADDR) bus_rdata[0] = flag_i;
  end

  a_r4_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_req, idle_req}));

  a_r9_ack_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (bus_wdata == '0) && bus_wr);

endmodule

// File: rtl/pmc_rcnt.sv
module pmc_rcnt #(
  parameter int REC_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int CW = (REC_CYC > 2) ? $clog2(REC_CYC) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt <= '0;
    else if (!done_o)     cnt <= cnt + 1'b1;
  end

  assign done_o = run_i && pmc_pkg::rec_last(int'(cnt), REC_CYC);

  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < REC_CYC);

  a_r6_cnt_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_i) |-> cnt == '0);

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     halt_req,
  input  logic     idle_req,
  input  logic     wake_i,
  input  logic     tmr_ovf_i,
  input  logic     rec_done,
  output pm_mode_e mode,
  output logic     exit_evt,
  output logic     in_recov
);

  pm_mode_e nxt;

  always_comb begin
    nxt      = mode;
    exit_evt = 1'b0;
    case (mode)
      PM_NORM: begin
        if (halt_req)      nxt = PM_HALT;
        else if (idle_req) nxt = PM_IDLE;
      end
      PM_HALT: begin
        if (wake_i) begin
          nxt      = PM_RECOV;
          exit_evt = 1'b1;
        end
      end
      PM_IDLE: begin
        if (wake_i || tmr_ovf_i) begin
          nxt      = PM_NORM;
          exit_evt = 1'b1;
        end
      end
      default: begin
        if (rec_done) nxt = PM_NORM;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= PM_NORM;
    else        mode <= nxt;
  end

  assign in_recov = (mode == PM_RECOV);

  a_r5_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_HALT && !wake_i) |=> mode == PM_HALT);

  a_r7_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_IDLE && (wake_i || tmr_ovf_i)) |=> mode == PM_NORM);

  a_r6_recov_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RECOV && $past(mode) != PM_RECOV) |-> $past(mode) == PM_HALT);

  a_r2_halt_from_norm: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_HALT && $past(mode) != PM_HALT) |-> $past(mode) == PM_NORM);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int REC_CYC = 1024,
  parameter logic [7:0] CTRL_ADDR = 8'hB7,
  parameter logic [7:0] ACK_ADDR  = 8'hB8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       wake_i,
  input  logic       tmr_ovf_i,
  output logic       cpu_run,
  output logic       osc_en,
  output logic       comp_en,
  output logic       bor_en,
  output logic [1:0] mode_code,
  output logic       resume_flag
);

  logic     halt_req, idle_req, ack_req;
  logic     exit_evt, in_recov, rec_done;
  pm_mode_e mode;

  pmc_regif #(
    .AW(8), .DW(8), .CTRL_ADDR(CTRL_ADDR), .ACK_ADDR(ACK_ADDR),
    .HALT_BIT(0), .IDLE_BIT(1)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .flag_i(resume_flag), .bus_rdata(bus_rdata),
    .halt_req(halt_req), .idle_req(idle_req), .ack_req(ack_req)
  );

  pmc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .idle_req(idle_req),
    .wake_i(wake_i), .tmr_ovf_i(tmr_ovf_i), .rec_done(rec_done),
    .mode(mode), .exit_evt(exit_evt), .in_recov(in_recov)
  );

  pmc_rcnt #(.REC_CYC(REC_CYC)) u_rcnt (
    .clk(clk), .rst_n(rst_n), .run_i(in_recov), .done_o(rec_done)
  );

  // an exit in the same cycle as an acknowledge keeps the flag set
  always_ff @(posedge clk) begin
    if (!rst_n)        resume_flag <= 1'b0;
    else if (exit_evt) resume_flag <= 1'b1;
    else if (ack_req)  resume_flag <= 1'b0;
  end

  assign {cpu_run, osc_en, comp_en, bor_en} = enables_for(mode);
  assign mode_code = mode;

  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> resume_flag);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_flag && !ack_req) |=> resume_flag);

  a_r6_run_after_recov: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_run) |-> $past(mode) == PM_RECOV || $past(mode) == PM_IDLE);

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;

  localparam int REC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wake_i = 1'b0;
  logic       tmr_ovf_i = 1'b0;
  logic       cpu_run, osc_en, comp_en, bor_en, resume_flag;
  logic [1:0] mode_code;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.REC_CYC(REC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_i(wake_i),
    .tmr_ovf_i(tmr_ovf_i), .cpu_run(cpu_run), .osc_en(osc_en),
    .comp_en(comp_en), .bor_en(bor_en), .mode_code(mode_code),
    .resume_flag(resume_flag)
  );

  typedef struct {
    logic [1:0] mode;
    logic [3:0] ens;
    logic       flag;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // bench model of the block
  logic [1:0] m_mode = 2'b00;
  int         m_cnt  = 0;
  logic       m_flag = 1'b0;

  function automatic logic [3:0] model_ens(logic [1:0] m);
    if (m == 2'b00) return 4'b1111;
    if (m == 2'b01) return 4'b0000;
    return 4'b0111;
  endfunction

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // monitor: compares the design's outputs against the queued expectations
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (mode_code !== e.mode || {cpu_run, osc_en, comp_en, bor_en} !== e.ens
          || resume_flag !== e.flag) begin
        n_bad++;
        $display("FAIL %s: mode=%b ens=%b flag=%b expected mode=%b ens=%b flag=%b",
                 e.req, mode_code, {cpu_run, osc_en, comp_en, bor_en}, resume_flag,
                 e.mode, e.ens, e.flag);
      end
    end
  end

  // driver: applies one cycle of stimulus, checks read data, pushes expectation
  task automatic step(bit wr, logic [7:0] a, logic [7:0] d, bit wk, bit tm, string req);
    logic [7:0] exp_rd;
    logic       set_f;
    exp_t       e;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; wake_i = wk; tmr_ovf_i = tm;
    #1;
    exp_rd = (a == 8'hB8) ? {7'b0, m_flag} : 8'h00;
    n_vec++;
    if (bus_rdata !== exp_rd) begin
      n_bad++;
      $display("FAIL %s (R8/R9 read): rdata=%h expected %h", req, bus_rdata, exp_rd);
    end
    set_f = 1'b0;
    case (m_mode)
      2'b00: if (wr && a == 8'hB7) begin
               if (d[0]) m_mode = 2'b01;
               else if (d[1]) m_mode = 2'b10;
             end
      2'b01: if (wk) begin m_mode = 2'b11; m_cnt = 0; set_f = 1'b1; end
      2'b10: if (wk || tm) begin m_mode = 2'b00; set_f = 1'b1; end
      default: if (m_cnt == REC - 1) m_mode = 2'b00; else m_cnt++;
    endcase
    if (set_f) m_flag = 1'b1;
    else if (wr && a == 8'hB8 && d == 8'h00) m_flag = 1'b0;
    @(posedge clk);
    e.mode = m_mode; e.ens = model_ens(m_mode); e.flag = m_flag; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle_cycles(int n, bit tm, string req);
    for (int i = 0; i < n; i++) step(0, 8'h00, 8'h00, 0, tm, req);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (mode_code !== 2'b00 || {cpu_run, osc_en, comp_en, bor_en} !== 4'b1111
        || resume_flag !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: mode=%b ens=%b flag=%b expected 00 1111 0",
               mode_code, {cpu_run, osc_en, comp_en, bor_en}, resume_flag);
    end
    rst_n = 1'b1;
    idle_cycles(2, 0, "R1");

    // R10: reserved bit and wrong address leave mode unchanged
    step(1, 8'hB7, 8'h04, 0, 0, "R10");
    step(1, 8'hB6, 8'h01, 0, 0, "R10");
    step(1, 8'hB7, 8'h00, 0, 0, "R10");

    // R2 + R5: enter halt, timer overflow and writes ignored
    step(1, 8'hB7, 8'h01, 0, 0, "R2");
    step(0, 8'hB7, 8'h00, 0, 1, "R5");
    idle_cycles(4, 1, "R5");
    step(1, 8'hB7, 8'h00, 0, 1, "R8");
    // R6: wakeup starts counted recovery
    step(0, 8'h00, 8'h00, 1, 0, "R6");
    idle_cycles(REC + 2, 0, "R6");
    // R9: nonzero ack keeps flag, zero ack clears it
    step(0, 8'hB8, 8'h00, 0, 0, "R9");
    step(1, 8'hB8, 8'h05, 0, 0, "R9");
    step(1, 8'hB8, 8'h00, 0, 0, "R9");
    step(0, 8'hB8, 8'h00, 0, 0, "R9");

    // R3 + R7: idle, exit on timer overflow, no recovery
    step(1, 8'hB7, 8'h02, 0, 0, "R3");
    idle_cycles(3, 0, "R3");
    step(0, 8'hB7, 8'h00, 0, 1, "R7");
    idle_cycles(2, 0, "R7");
    step(1, 8'hB8, 8'h00, 0, 0, "R9");

    // R7: idle exit on wakeup
    step(1, 8'hB7, 8'h02, 0, 0, "R3");
    step(0, 8'h00, 8'h00, 1, 0, "R7");
    idle_cycles(2, 0, "R7");

    // R4: both request bits gives halt
    step(1, 8'hB7, 8'h03, 0, 0, "R4");
    idle_cycles(2, 1, "R4");
    step(0, 8'h00, 8'h00, 1, 1, "R6");
    idle_cycles(REC + 1, 0, "R6");
    step(1, 8'hB8, 8'h00, 0, 0, "R9");
    step(0, 8'hB8, 8'h00, 0, 0, "R9");

    @(negedge clk);
    @(negedge clk);
    finish_sim();
  end

endmodule